// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block is a small bank of configuration registers that sits between a register bus and a PLL. It holds the divider settings, the fractional word, the integer-mode flag and the power-down control. The decoded fields are driven straight to the PLL, and a lock indication from the PLL is returned on reads.

Registers sit at byte offsets that are four times their index. The two control words use a masked-write scheme: the upper half of each 32-bit write selects which bits of the lower half change. Software can therefore flip a single field, such as power-down, without reading the register first. The fractional word is an ordinary register: a write stores its value bits whole.

Reads are registered, with a one-cycle acknowledge. Offsets that decode to no register read as zero and discard writes.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the fields are: feedback divider 64, post-divider 1 = 1, reference divider 1, post-divider 2 = 1, integer mode 1, power-down 1, fraction 0. Register 0 reads 0x00001040, register 1 reads 0x00003041 and register 2 reads 0x00000000 while the lock input is low.
- R2: On a write to register 0 or register 1, bit i (0..15) of the stored word takes write-data bit i only when write-data bit i+16 is 1. Every other bit keeps its value, so a write with a zero upper half changes nothing.
- R3: Register 0 (byte offset 0x0) holds the feedback divider in bits 11:0 and post-divider 1 in bits 14:12. Bit 15 is not stored and reads 0.
- R4: Register 1 (byte offset 0x4) holds the reference divider in bits 5:0, post-divider 2 in bits 8:6, the integer-mode flag in bit 12 and power-down in bit 13. Power-down 1 turns the PLL off. Bits 11:9 and 15:14 are not stored and read 0.
- R5: Register 2 (byte offset 0x8) stores write-data bits 23:0 as the 24-bit fraction on every write to it, with no mask semantics. Write-data bits 31:24 are discarded.
- R6: Reads of register 0 and register 1 return 0 in bits 31:16.
- R7: A read of register 2 returns the fraction in bits 23:0, zeros in bits 30:24, and the lock input in bit 31 after a synchronizer of SYNC_STAGES flops (2 by default).
- R8: An offset that is not 0x0, 0x4 or 0x8 (including a misaligned one) reads as 0, and a write to it changes no field.
- R9: rd_ack is 1 in exactly the cycle after one in which rd_en was 1, and rdata is valid in that cycle.
- R10: When a read and a write to the same register fall in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_ack | output | 1 | Read data valid |
| lock_in | input | 1 | Lock indication from the PLL, asynchronous |
| fb_div | output | 12 | Feedback divider |
| post_div1 | output | 3 | First post-divider |
| ref_div | output | 6 | Reference divider |
| post_div2 | output | 3 | Second post-divider |
| int_mode | output | 1 | Integer mode, fraction unused when 1 |
| pwr_down | output | 1 | PLL power-down |
| frac | output | 24 | Fractional feedback word |

## Verification
The hardest cases to reach are writes whose mask half is only partly set. Such a write must move one field while its neighbour in the same word stays put, and the bit-15 and unstored bits of register 1 must stay zero even when a write sets every bit. The stimulus drives partial masks on each field, an empty mask, and an all-ones word.

A read and a write to the same register are also issued in one cycle, so the returned word shows whether the read captured the old value. The lock bit is raised and lowered and read only after the synchronizer depth has passed. This exposes both the bit position and the synchronizer latency.

// File: rtl/pllreg_pkg.sv
// Package pllreg_pkg
// Shared layout constants for the PLL configuration register bank.
// Assumes a 32-bit data bus with a 16-bit write-mask half on the control words.
package pllreg_pkg;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = 16;
    localparam int FRAC_W     = 24;
    localparam int NUM_REGS   = 3;
    localparam int NUM_MASKED = 2;
    localparam int FRAC_IDX   = 2;

    // stored-bit masks and reset words of the two masked control words
    localparam logic [HALF_W-1:0] CTL0_KEEP = 16'h7FFF;
    localparam logic [HALF_W-1:0] CTL1_KEEP = 16'h31FF;
    localparam logic [HALF_W-1:0] CTL0_RST  = 16'h1040;
    localparam logic [HALF_W-1:0] CTL1_RST  = 16'h3041;

    // field positions
    localparam int FB_LSB   = 0;   localparam int FB_W   = 12;
    localparam int PD1_LSB  = 12;  localparam int PD1_W  = 3;
    localparam int REF_LSB  = 0;   localparam int REF_W  = 6;
    localparam int PD2_LSB  = 6;   localparam int PD2_W  = 3;
    localparam int INT_BIT  = 12;
    localparam int PWR_BIT  = 13;

    // stored-bit mask of masked word i
    function automatic logic [HALF_W-1:0] keep_of(input int i);
        return (i == 0) ? CTL0_KEEP : CTL1_KEEP;
    endfunction

    // reset word of masked word i
    function automatic logic [HALF_W-1:0] rst_of(input int i);
        return (i == 0) ? CTL0_RST : CTL1_RST;
    endfunction
endpackage

// File: rtl/pllreg_decode.sv
// Module pllreg_decode
// Turns a byte offset into a one-hot write select, a register index and a hit flag.
// Assumes word-aligned registers at four times their index; anything else misses.
module pllreg_decode
    import pllreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [IDX_W-1:0]    idx,
    output logic                hit
);
    logic aligned;

    // split offset into word index and alignment check
    always_comb begin
        idx     = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        hit     = aligned && (int'(idx) < NUM_REGS);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_sel
            // write select for register g
            assign wr_sel[g] = wr_en && aligned && (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/pllreg_mask_reg.sv
// Module pllreg_mask_reg
// One 16-bit control word where the upper half of the write data enables each lower bit.
// Assumes unstored bits (KEEP = 0) are held at zero and never written.
module pllreg_mask_reg
    import pllreg_pkg::*;
#(
    parameter logic [HALF_W-1:0] KEEP = 16'hFFFF,
    parameter logic [HALF_W-1:0] RST  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF_W-1:0] q
);
    logic [HALF_W-1:0] en;
    logic [HALF_W-1:0] nxt;

    // per-bit enable from the mask half, limited to stored bits
    always_comb begin
        en  = wdata[DATA_W-1:HALF_W] & KEEP;
        nxt = (q & ~en) | (wdata[HALF_W-1:0] & en);
    end

    // storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST & KEEP;
        else if (wr) q <= nxt;
    end
endmodule

// File: rtl/pllreg_word_reg.sv
// Module pllreg_word_reg
// Plain register of WIDTH bits loaded whole from the low write-data bits.
// Assumes no mask semantics; write-data bits above WIDTH are dropped.
module pllreg_word_reg
    import pllreg_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIDTH-1:0]  q
);
    // storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata[WIDTH-1:0];
    end
endmodule

// File: rtl/pllreg_sync.sv
// Module pllreg_sync
// Flop chain that brings the asynchronous lock indication into the bus clock domain.
// Assumes STAGES >= 1; output is zero during reset.
module pllreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pllreg_rdmux.sv
// Module pllreg_rdmux
// Selects the read word and registers it together with the acknowledge.
// Assumes the lock bit sits at the top of the fraction word; misses read zero.
module pllreg_rdmux
    import pllreg_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_en,
    input  logic                               hit,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [NUM_MASKED-1:0][HALF_W-1:0]  ctl_q,
    input  logic [FRAC_W-1:0]                  frac_q,
    input  logic                               lock_s,
    output logic [DATA_W-1:0]                  rdata,
    output logic                               rd_ack
);
    logic [DATA_W-1:0] word;

    // pick the addressed word
    always_comb begin
        word = '0;
        if (hit) begin
            for (int i = 0; i < NUM_MASKED; i++) begin
                if (idx == IDX_W'(i)) word = {{(DATA_W-HALF_W){1'b0}}, ctl_q[i]};
            end
            if (idx == IDX_W'(FRAC_IDX))
                word = {lock_s, {(DATA_W-1-FRAC_W){1'b0}}, frac_q};
        end
    end

    // capture read data and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_ack <= 1'b0;
        end else begin
            rd_ack <= rd_en;
            if (rd_en) rdata <= word;
        end
    end
endmodule

// File: rtl/pll_cfg_regs.sv
// Module pll_cfg_regs
// PLL configuration register bank: two write-masked control words, one plain
// fraction word with lock status folded into its read value.
// Assumes a single-cycle write strobe and a registered one-cycle read.
module pll_cfg_regs
    import pllreg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_ack,
    input  logic              lock_in,
    output logic [FB_W-1:0]   fb_div,
    output logic [PD1_W-1:0]  post_div1,
    output logic [REF_W-1:0]  ref_div,
    output logic [PD2_W-1:0]  post_div2,
    output logic              int_mode,
    output logic              pwr_down,
    output logic [FRAC_W-1:0] frac
);
    logic [NUM_REGS-1:0]              wr_sel;
    logic [IDX_W-1:0]                 idx;
    logic                             hit;
    logic [NUM_MASKED-1:0][HALF_W-1:0] ctl_q;
    logic [FRAC_W-1:0]                frac_q;
    logic                             lock_s;

    pllreg_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr(addr), .wr_en(wr_en), .wr_sel(wr_sel), .idx(idx), .hit(hit)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_MASKED; g++) begin : g_ctl
            pllreg_mask_reg #(.KEEP(keep_of(g)), .RST(rst_of(g))) reg_i (
                .clk(clk), .rst_n(rst_n), .wr(wr_sel[g]), .wdata(wdata), .q(ctl_q[g])
            );
        end
    endgenerate

    pllreg_word_reg #(.WIDTH(FRAC_W)) frac_i (
        .clk(clk), .rst_n(rst_n), .wr(wr_sel[FRAC_IDX]), .wdata(wdata), .q(frac_q)
    );

    pllreg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(lock_in), .q(lock_s)
    );

    pllreg_rdmux #(.IDX_W(IDX_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .idx(idx),
        .ctl_q(ctl_q), .frac_q(frac_q), .lock_s(lock_s), .rdata(rdata), .rd_ack(rd_ack)
    );

    // field extraction toward the PLL
    always_comb begin
        fb_div    = ctl_q[0][FB_LSB +: FB_W];
        post_div1 = ctl_q[0][PD1_LSB +: PD1_W];
        ref_div   = ctl_q[1][REF_LSB +: REF_W];
        post_div2 = ctl_q[1][PD2_LSB +: PD2_W];
        int_mode  = ctl_q[1][INT_BIT];
        pwr_down  = ctl_q[1][PWR_BIT];
        frac      = frac_q;
    end
endmodule

// File: rtl/pll_cfg_regs_chk.sv
// Module pll_cfg_regs_chk
// Port-level properties of the register bank, bound into every instance.
// Assumes synchronous active-low reset; all checks are disabled during reset.
module pll_cfg_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              rd_ack,
    input logic [11:0]       fb_div,
    input logic [2:0]        post_div1,
    input logic [5:0]        ref_div,
    input logic [2:0]        post_div2,
    input logic              int_mode,
    input logic              pwr_down,
    input logic [23:0]       frac
);
    logic at0, at4, at8, known;

    // offset classes seen by the checker
    always_comb begin
        at0   = (addr == ADDR_W'(0));
        at4   = (addr == ADDR_W'(4));
        at8   = (addr == ADDR_W'(8));
        known = at0 || at4 || at8;
    end

    // R1
    rst_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwr_down && int_mode && fb_div == 12'd64));

    // R2
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at0 && wdata[31:16] == 16'h0) |=> ($stable(fb_div) && $stable(post_div1)));

    // R5
    frac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at8) |=> (frac == $past(wdata[23:0])));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (at0 || at4)) |=> (rdata[31:16] == 16'h0));

    // R8
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !known) |=> $stable({fb_div, post_div1, ref_div, post_div2, int_mode, pwr_down, frac}));

    // R8
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !known) |=> (rdata == 32'h0));

    // R9
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_ack);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_ack);

    // R10
    old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && at8) |=> (rdata[23:0] == $past(frac)));
endmodule

bind pll_cfg_regs pll_cfg_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_ack(rd_ack), .fb_div(fb_div),
    .post_div1(post_div1), .ref_div(ref_div), .post_div2(post_div2),
    .int_mode(int_mode), .pwr_down(pwr_down), .frac(frac)
);

// File: tb/pll_cfg_regs_tb_top.sv
// Scoreboard bench for pll_cfg_regs: driver tasks queue expected read words,
// a monitor compares them when rd_ack appears; field ports are checked directly.
module pll_cfg_regs_tb_top;
    localparam int ADDR_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, lock_in = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_ack;
    logic [11:0] fb_div;
    logic [2:0]  post_div1, post_div2;
    logic [5:0]  ref_div;
    logic        int_mode, pwr_down;
    logic [23:0] frac;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    pll_cfg_regs #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_ack(rd_ack), .lock_in(lock_in),
        .fb_div(fb_div), .post_div1(post_div1), .ref_div(ref_div),
        .post_div2(post_div2), .int_mode(int_mode), .pwr_down(pwr_down), .frac(frac)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one bus cycle, started and ended at a falling edge
    task automatic bus(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic [31:0] exp, input string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        if (r) sb_q.push_back('{exp, tag});
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus(1'b1, 1'b0, a, d, 32'h0, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus(1'b0, 1'b1, a, 32'h0, exp, tag);
    endtask

    // monitor: compare each acknowledged read against the queue head
    always @(negedge clk) begin
        if (rst_n && rd_ack) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected rd_ack, actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, rdata, e.exp);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 fb_div", 32'(fb_div), 32'd64);
        check("R1 post_div1", 32'(post_div1), 32'd1);
        check("R1 ref_div", 32'(ref_div), 32'd1);
        check("R1 post_div2", 32'(post_div2), 32'd1);
        check("R1 int_mode", 32'(int_mode), 32'd1);
        check("R1 pwr_down", 32'(pwr_down), 32'd1);
        check("R1 frac", 32'(frac), 32'd0);
        rd(4'h0, 32'h0000_1040, "R1 reg0");
        rd(4'h4, 32'h0000_3041, "R1 reg1");
        rd(4'h8, 32'h0000_0000, "R1 reg2");
        check("R9 idle ack", 32'(rd_ack), 32'd1);
        @(negedge clk);
        check("R9 ack low", 32'(rd_ack), 32'd0);

        // R2/R3 partial masks on register 0
        wr(4'h0, 32'h0FFF_0123);
        check("R3 fb_div", 32'(fb_div), 32'h123);
        check("R2 post_div1 kept", 32'(post_div1), 32'd1);
        wr(4'h0, 32'h7000_5ABC);
        check("R3 post_div1", 32'(post_div1), 32'd5);
        check("R2 fb_div kept", 32'(fb_div), 32'h123);
        wr(4'h0, 32'h0000_FFFF);
        rd(4'h0, 32'h0000_5123, "R2 empty mask");
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'h0000_7FFF, "R3 bit15 unstored");

        // R4 register 1
        wr(4'h4, 32'h2000_0000);
        check("R4 pwr_down cleared", 32'(pwr_down), 32'd0);
        rd(4'h4, 32'h0000_1041, "R4 reg1 enabled");
        wr(4'h4, 32'h11FF_00EA);
        check("R4 ref_div", 32'(ref_div), 32'h2A);
        check("R4 post_div2", 32'(post_div2), 32'd3);
        check("R4 int_mode", 32'(int_mode), 32'd0);
        check("R4 pwr_down kept", 32'(pwr_down), 32'd0);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, 32'h0000_31FF, "R6 reg1 unstored bits");
        check("R4 pwr_down set", 32'(pwr_down), 32'd1);

        // R5 fraction word
        wr(4'h8, 32'hABCD_EF12);
        check("R5 frac", 32'(frac), 32'h00CD_EF12);
        rd(4'h8, 32'h00CD_EF12, "R5 reg2");
        wr(4'h8, 32'h0000_0005);
        check("R5 no mask", 32'(frac), 32'd5);

        // R7 lock bit
        lock_in = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'h8, 32'h8000_0005, "R7 locked");
        lock_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'h8, 32'h0000_0005, "R7 unlocked");

        // R8 undefined offsets
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'hC, 32'h0, "R8 read 0xC");
        rd(4'h5, 32'h0, "R8 read misaligned");
        rd(4'h0, 32'h0000_7FFF, "R8 reg0 untouched");
        rd(4'h4, 32'h0000_31FF, "R8 reg1 untouched");
        rd(4'h8, 32'h0000_0005, "R8 reg2 untouched");

        // R10 read and write in one cycle
        bus(1'b1, 1'b1, 4'h8, 32'h0000_0077, 32'h0000_0005, "R10 old value");
        rd(4'h8, 32'h0000_0077, "R10 new value");
        bus(1'b1, 1'b1, 4'h0, 32'h0FFF_0001, 32'h0000_7FFF, "R10 reg0 old value");
        check("R10 reg0 updated", 32'(fb_div), 32'h001);

        repeat (2) @(negedge clk);
        check("R9 queue drained", 32'(sb_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule